// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block feeds a programmable feedback counter in a frequency synthesizer loop. It delivers one integer divide value for every feedback cycle. The values are dithered by a third-order noise-shaping modulator, so that their long-run mean is INT + FRAC/MOD. The modulus MOD is programmable and need not be a power of two. The divider counter asserts a one-cycle strobe when it finishes a count. On that strobe the sequencer either takes a new setting or advances the modulator by one step. The registered divide output then holds until the next strobe.

Three cascaded accumulators wrap modulo MOD. Their carries are combined into a signed offset between -3 and +4, and the offset is added to INT. When FRAC is zero and the integer-only control is set, the modulator is bypassed and INT is issued unchanged. A setting outside its legal range raises an error flag, and the last good divide value is kept. A change of setting clears the modulator, so a given setting always produces the same sequence.

Top module: `fracn_ratio_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `div_val` is 0 and `range_err` is 0.
- R2: Inputs are sampled only on a cycle where `cyc_end` is 1. With `cyc_end` low, changing any input leaves `div_val` and `range_err` unchanged.
- R3: A strobe whose setting (INT, FRAC, MOD, prescaler select, spur mode, integer-only bit) differs from the active one reloads. If the new setting is legal, the modulator is cleared, `div_val` equals INT after that edge and `range_err` is 0.
- R4: In fractional mode with FRAC = 0, every output equals INT.
- R5: Integer-only operation applies when `int_mode` = 1 and FRAC = 0. Every output is then INT and MOD is not range-checked, so MOD = 0 is accepted. With `int_mode` = 1 and FRAC not 0, the block operates fractionally.
- R6: Every output of a legal setting lies in [INT-3, INT+4].
- R7: Over the first N outputs after a reload output, the sum minus N*INT minus floor(N*FRAC/MOD) lies in [-1, +2]. The mean over k*MOD outputs is therefore INT + FRAC/MOD to within 2/(k*MOD).
- R8: With `presc_hi` = 0 (4/5 prescaler), INT must lie in 23..32767.
- R9: With `presc_hi` = 1 (8/9 prescaler), INT must lie in 75..65535.
- R10: MOD must lie in 2..4095 with `spur_mode` = 0 and in 50..4095 with `spur_mode` = 1.
- R11: FRAC must be less than MOD.
- R12: An illegal setting at reload sets `range_err` to 1 and holds `div_val` at its previous value. Later strobes with the same setting keep both unchanged. A later legal setting reloads as in R3.
- R13: Two reloads of the same legal setting produce identical output sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_end | input | 1 | One-cycle strobe at the end of each divider cycle |
| int_word | input | 16 | Integer part INT |
| frac_word | input | 12 | Fraction numerator FRAC |
| mod_word | input | 12 | Fraction modulus MOD |
| presc_hi | input | 1 | 1 selects the 8/9 prescaler INT range, 0 the 4/5 range |
| spur_mode | input | 1 | 1 raises the minimum MOD to 50 |
| int_mode | input | 1 | Integer-only request, effective when FRAC is 0 |
| div_val | output | 17 | Divide value for the current feedback cycle |
| range_err | output | 1 | Active setting is out of range |

## Verification
An accumulator that fails to wrap, or that carries one time too many, does not show in any single output, which always stays within a few counts of INT. It shows as a drift of the running sum away from N*INT + floor(N*FRAC/MOD). That drift leaves the two-count tolerance within one modulus period of strobes, so the windowed sum checks over one to three periods catch it. Stale noise-shaper history left across a reload shows in the first few outputs. Replaying a setting and comparing the sequence cycle for cycle exposes it. Wrong range decoding shows at the reload edge itself, as a wrong `range_err` or a moved `div_val`.

// File: rtl/frac_seq_pkg.sv
package frac_seq_pkg;

    // datapath widths shared by the sequencer and its neighbours
    localparam int INT_W   = 16;
    localparam int MOD_W   = 12;
    localparam int DIV_W   = INT_W + 1;
    localparam int STAGES  = 3;
    localparam int OFFS_W  = 4;

    // active setting, compared as a whole against the incoming words
    typedef struct packed {
        logic [INT_W-1:0] int_w;
        logic [MOD_W-1:0] frac_w;
        logic [MOD_W-1:0] mod_w;
        logic             presc_hi;
        logic             spur_mode;
        logic             int_mode;
    } ratio_cfg_t;

    // what a strobe does this cycle
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_RELOAD = 2'd1,
        ACT_STEP   = 2'd2,
        ACT_HOLD   = 2'd3
    } seq_act_e;

    typedef logic signed [OFFS_W-1:0] offs_t;

    // sign-extend a modulator offset to the divide width plus one guard bit
    function automatic logic [DIV_W:0] widen_offs(input offs_t o);
        return {{(DIV_W + 1 - OFFS_W){o[OFFS_W-1]}}, o};
    endfunction

endpackage

// File: rtl/fracn_cfg_check.sv
module fracn_cfg_check
    import frac_seq_pkg::*;
#(
    parameter int IW        = INT_W,
    parameter int MW        = MOD_W,
    parameter int LO_P45    = 23,
    parameter int HI_P45    = 32767,
    parameter int LO_P89    = 75,
    parameter int MOD_LO_LN = 2,
    parameter int MOD_LO_LS = 50
) (
    input  logic [IW-1:0] int_w,
    input  logic [MW-1:0] frac_w,
    input  logic [MW-1:0] mod_w,
    input  logic          presc_hi,
    input  logic          spur_mode,
    input  logic          int_mode,
    output logic          legal,
    output logic          int_only
);
    localparam logic [IW-1:0] I_LO45 = IW'(LO_P45);
    localparam logic [IW-1:0] I_HI45 = IW'(HI_P45);
    localparam logic [IW-1:0] I_LO89 = IW'(LO_P89);
    localparam logic [MW-1:0] M_LOLN = MW'(MOD_LO_LN);
    localparam logic [MW-1:0] M_LOLS = MW'(MOD_LO_LS);

    logic int_ok, mod_ok, frac_ok;
    logic [MW-1:0] mod_floor;

    always_comb begin
        int_only  = int_mode && (frac_w == '0);
        mod_floor = spur_mode ? M_LOLS : M_LOLN;
        if (presc_hi)
            int_ok = (int_w >= I_LO89);
        else
            int_ok = (int_w >= I_LO45) && (int_w <= I_HI45);
        mod_ok  = int_only || (mod_w >= mod_floor);
        frac_ok = int_only || (frac_w < mod_w);
        legal   = int_ok && mod_ok && frac_ok;
    end

    // R11
    frac_bound_chk: assert final (!(legal && !int_only) || frac_w < mod_w);

endmodule

// File: rtl/fracn_mod_acc.sv
module fracn_mod_acc
    import frac_seq_pkg::*;
#(
    parameter int W = MOD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] addend,
    input  logic [W-1:0] modulus,
    output logic [W-1:0] sum_now,
    output logic         carry
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum_raw;
    logic [W:0]   sum_wrap;

    always_comb begin
        sum_raw  = {1'b0, acc_q} + {1'b0, addend};
        sum_wrap = sum_raw - {1'b0, modulus};
        carry    = (sum_raw >= {1'b0, modulus});
        sum_now  = carry ? sum_wrap[W-1:0] : sum_raw[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (step)
            acc_q <= sum_now;
    end

    // R7
    acc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && addend < modulus && acc_q < modulus) |=> (acc_q < $past(modulus)));

endmodule

// File: rtl/fracn_noise_shaper.sv
module fracn_noise_shaper
    import frac_seq_pkg::*;
#(
    parameter int N_CY = STAGES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            step,
    input  logic [N_CY-1:0] cy,
    output offs_t           offset
);
    logic c2_d1;
    logic c3_d1, c3_d2;
    logic [OFFS_W-1:0] pos_sum, neg_sum;

    always_comb begin
        pos_sum = OFFS_W'(cy[0]) + OFFS_W'(cy[1]) + OFFS_W'(cy[2]) + OFFS_W'(c3_d2);
        neg_sum = OFFS_W'(c2_d1) + OFFS_W'({c3_d1, 1'b0});
        offset  = offs_t'(pos_sum - neg_sum);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else if (step) begin
            c2_d1 <= cy[1];
            c3_d1 <= cy[2];
            c3_d2 <= c3_d1;
        end
    end

    // R6
    offs_span_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> (offset >= -4'sd3 && offset <= 4'sd4));

endmodule

// File: rtl/fracn_ratio_seq.sv
module fracn_ratio_seq
    import frac_seq_pkg::*;
#(
    parameter int INT_LO_P45 = 23,
    parameter int INT_HI_P45 = 32767,
    parameter int INT_LO_P89 = 75,
    parameter int MOD_LO_LN  = 2,
    parameter int MOD_LO_LS  = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_end,
    input  logic [INT_W-1:0] int_word,
    input  logic [MOD_W-1:0] frac_word,
    input  logic [MOD_W-1:0] mod_word,
    input  logic             presc_hi,
    input  logic             spur_mode,
    input  logic             int_mode,
    output logic [DIV_W-1:0] div_val,
    output logic             range_err
);
    ratio_cfg_t cfg_in, cfg_q;
    logic       loaded_q, err_q, int_only_q;
    logic       legal_in, int_only_in, cfg_diff;
    seq_act_e   act;
    logic [DIV_W-1:0] div_q, div_step;
    logic [DIV_W:0]   div_wide;
    offs_t      offset;
    logic       mod_clr, mod_step;

    logic [STAGES-1:0][MOD_W-1:0] st_in;
    logic [STAGES-1:0][MOD_W-1:0] st_sum;
    logic [STAGES-1:0]            st_cy;

    assign cfg_in = '{int_w: int_word, frac_w: frac_word, mod_w: mod_word,
                      presc_hi: presc_hi, spur_mode: spur_mode, int_mode: int_mode};

    fracn_cfg_check #(
        .IW(INT_W), .MW(MOD_W),
        .LO_P45(INT_LO_P45), .HI_P45(INT_HI_P45), .LO_P89(INT_LO_P89),
        .MOD_LO_LN(MOD_LO_LN), .MOD_LO_LS(MOD_LO_LS)
    ) u_check (
        .int_w(int_word), .frac_w(frac_word), .mod_w(mod_word),
        .presc_hi(presc_hi), .spur_mode(spur_mode), .int_mode(int_mode),
        .legal(legal_in), .int_only(int_only_in)
    );

    always_comb begin
        cfg_diff = !loaded_q || (cfg_in != cfg_q);
        if (!cyc_end)      act = ACT_IDLE;
        else if (cfg_diff) act = ACT_RELOAD;
        else if (err_q)    act = ACT_HOLD;
        else               act = ACT_STEP;
        mod_clr  = (act == ACT_RELOAD);
        mod_step = (act == ACT_STEP) && !int_only_q;
    end

    // cascade of modulo-MOD accumulators, each fed by the previous sum
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign st_in[g] = cfg_q.frac_w;
        end else begin : g_tail
            assign st_in[g] = st_sum[g-1];
        end
        fracn_mod_acc #(.W(MOD_W)) u_acc (
            .clk(clk), .rst(rst), .clr(mod_clr), .step(mod_step),
            .addend(st_in[g]), .modulus(cfg_q.mod_w),
            .sum_now(st_sum[g]), .carry(st_cy[g])
        );
    end

    fracn_noise_shaper #(.N_CY(STAGES)) u_shape (
        .clk(clk), .rst(rst), .clr(mod_clr), .step(mod_step),
        .cy(st_cy), .offset(offset)
    );

    always_comb begin
        div_wide = {2'b00, cfg_q.int_w} + widen_offs(offset);
        div_step = int_only_q ? {1'b0, cfg_q.int_w} : div_wide[DIV_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            loaded_q   <= 1'b0;
            err_q      <= 1'b0;
            int_only_q <= 1'b0;
            div_q      <= '0;
        end else begin
            unique case (act)
                ACT_RELOAD: begin
                    cfg_q      <= cfg_in;
                    loaded_q   <= 1'b1;
                    err_q      <= !legal_in;
                    int_only_q <= int_only_in;
                    if (legal_in)
                        div_q <= {1'b0, int_word};
                end
                ACT_STEP:  div_q <= div_step;
                ACT_HOLD:  div_q <= div_q;
                default:   div_q <= div_q;
            endcase
        end
    end

    assign div_val   = div_q;
    assign range_err = err_q;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_end |=> ($stable(div_val) && $stable(range_err)));

    // R3
    reload_int_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_end && cfg_diff && legal_in) |=> (div_val == {1'b0, $past(int_word)} && !range_err));

    // R12
    bad_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_end && cfg_diff && !legal_in) |=> ($stable(div_val) && range_err));

    // R6
    out_window_chk: assert property (@(posedge clk) disable iff (rst)
        (loaded_q && !err_q) |-> ((div_val + 3 >= {1'b0, cfg_q.int_w}) &&
                                  (div_val <= {1'b0, cfg_q.int_w} + 4)));

    // R5
    int_only_chk: assert property (@(posedge clk) disable iff (rst)
        (loaded_q && !err_q && int_only_q) |-> (div_val == {1'b0, cfg_q.int_w}));

endmodule

// File: tb/fracn_ratio_seq_tb.sv
module fracn_ratio_seq_tb;
    import frac_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cyc_end = 1'b0;
    logic [INT_W-1:0] int_word = '0;
    logic [MOD_W-1:0] frac_word = '0;
    logic [MOD_W-1:0] mod_word = '0;
    logic             presc_hi = 1'b0;
    logic             spur_mode = 1'b0;
    logic             int_mode = 1'b0;
    logic [DIV_W-1:0] div_val;
    logic             range_err;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fracn_ratio_seq u_dut (
        .clk(clk), .rst(rst), .cyc_end(cyc_end),
        .int_word(int_word), .frac_word(frac_word), .mod_word(mod_word),
        .presc_hi(presc_hi), .spur_mode(spur_mode), .int_mode(int_mode),
        .div_val(div_val), .range_err(range_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int iv, input int fv, input int mv,
                           input bit ph, input bit sm, input bit im);
        int_word  = INT_W'(iv);
        frac_word = MOD_W'(fv);
        mod_word  = MOD_W'(mv);
        presc_hi  = ph;
        spur_mode = sm;
        int_mode  = im;
    endtask

    // one strobe; on return the updated outputs are stable
    task automatic pulse();
        @(negedge clk);
        cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(div_val == 0, "R1 div in reset", div_val, 0);
        check(range_err == 0, "R1 err in reset", range_err, 0);
        rst = 1'b0;
        @(negedge clk);
        check(div_val == 0 && range_err == 0, "R1 after reset", div_val, 0);
    endtask

    // R4: fractional mode with zero numerator never dithers
    task automatic t_zero_frac();
        int bad = 0;
        set_cfg(500, 0, 97, 0, 0, 0);
        pulse();
        for (int i = 0; i < 50; i++) begin
            pulse();
            if (div_val != 500) bad++;
        end
        check(bad == 0, "R4 frac zero outputs", bad, 0);
    endtask

    // R5: integer-only bypass, MOD ignored, then fractional with int_mode set
    task automatic t_int_mode();
        int bad = 0;
        set_cfg(1234, 0, 0, 0, 0, 1);
        pulse();
        check(range_err == 0, "R5 mod 0 accepted", range_err, 0);
        for (int i = 0; i < 20; i++) begin
            pulse();
            if (div_val != 1234) bad++;
        end
        check(bad == 0, "R5 integer-only outputs", bad, 0);
    endtask

    // R3 R6 R7: reload value, per-output window, windowed sum
    task automatic t_window(input int iv, input int fv, input int mv,
                            input bit ph, input bit sm, input bit im, input int n);
        longint sum = 0;
        longint resid;
        int out_bad = 0;
        set_cfg(iv, fv, mv, ph, sm, im);
        pulse();
        check(div_val == DIV_W'(iv) && range_err == 0, "R3 reload gives INT", div_val, iv);
        for (int i = 0; i < n; i++) begin
            pulse();
            sum += longint'(div_val);
            if (longint'(div_val) < iv - 3 || longint'(div_val) > iv + 4) out_bad++;
        end
        check(out_bad == 0, "R6 output window", out_bad, 0);
        resid = sum - longint'(n) * iv - (longint'(n) * fv) / mv;
        check(resid >= -1 && resid <= 2, "R7 windowed sum residual", resid, 0);
    endtask

    // R8 R9 R10 R11 R5 R12: legality at reload
    task automatic t_limit(input int iv, input int fv, input int mv, input bit ph,
                           input bit sm, input bit im, input bit exp_err, input string req);
        logic [DIV_W-1:0] prev;
        prev = div_val;
        set_cfg(iv, fv, mv, ph, sm, im);
        pulse();
        check(range_err == exp_err, req, range_err, exp_err);
        if (exp_err)
            check(div_val == prev, "R12 hold on bad setting", div_val, prev);
        else
            check(div_val == DIV_W'(iv), req, div_val, iv);
    endtask

    task automatic t_limits();
        t_limit(22,    0, 10,   0, 0, 0, 1, "R8 INT 22 with 4/5");
        t_limit(23,    0, 10,   0, 0, 0, 0, "R8 INT 23 with 4/5");
        t_limit(32767, 0, 10,   0, 0, 0, 0, "R8 INT 32767 with 4/5");
        t_limit(32768, 0, 10,   0, 0, 0, 1, "R8 INT 32768 with 4/5");
        t_limit(32768, 0, 10,   1, 0, 0, 0, "R9 INT 32768 with 8/9");
        t_limit(74,    0, 10,   1, 0, 0, 1, "R9 INT 74 with 8/9");
        t_limit(75,    0, 10,   1, 0, 0, 0, "R9 INT 75 with 8/9");
        t_limit(65535, 0, 10,   1, 0, 0, 0, "R9 INT 65535 with 8/9");
        t_limit(100,   0, 1,    0, 0, 0, 1, "R10 MOD 1 low-noise");
        t_limit(100,   0, 2,    0, 0, 0, 0, "R10 MOD 2 low-noise");
        t_limit(100,   0, 49,   0, 1, 0, 1, "R10 MOD 49 low-spur");
        t_limit(100,   0, 50,   0, 1, 0, 0, "R10 MOD 50 low-spur");
        t_limit(100,   0, 4095, 0, 1, 0, 0, "R10 MOD 4095 low-spur");
        t_limit(100,   10, 10,  0, 0, 0, 1, "R11 FRAC equal MOD");
        t_limit(100,   9, 10,   0, 0, 0, 0, "R11 FRAC MOD-1");
        t_limit(100,   0, 0,    0, 0, 1, 0, "R5 integer-only MOD 0");
        t_limit(100,   0, 0,    0, 0, 0, 1, "R10 MOD 0 fractional");
    endtask

    // R12: repeated strobes on a bad setting hold; recovery reloads
    task automatic t_err_hold();
        logic [DIV_W-1:0] held;
        int moved = 0;
        set_cfg(300, 5, 7, 0, 0, 0);
        pulse();
        repeat (4) pulse();
        held = div_val;
        set_cfg(300, 8, 7, 0, 0, 0);
        pulse();
        check(range_err == 1 && div_val == held, "R12 bad setting held", div_val, held);
        for (int i = 0; i < 5; i++) begin
            pulse();
            if (div_val != held || range_err != 1) moved++;
        end
        check(moved == 0, "R12 hold over strobes", moved, 0);
        set_cfg(301, 5, 7, 0, 0, 0);
        pulse();
        check(range_err == 0 && div_val == 301, "R12 recovery reload", div_val, 301);
    endtask

    // R2: no strobe, no change
    task automatic t_no_strobe();
        logic [DIV_W-1:0] was;
        logic was_err;
        set_cfg(400, 3, 11, 0, 0, 0);
        pulse();
        repeat (3) pulse();
        was = div_val;
        was_err = range_err;
        set_cfg(22, 20, 1, 0, 1, 0);
        repeat (6) @(negedge clk);
        check(div_val == was, "R2 div held without strobe", div_val, was);
        check(range_err == was_err, "R2 err held without strobe", range_err, was_err);
        pulse();
        check(range_err == 1, "R2 taken at strobe", range_err, 1);
    endtask

    // R13: replayed setting yields the same sequence
    task automatic t_replay();
        logic [DIV_W-1:0] first [40];
        int diff = 0;
        set_cfg(800, 13, 29, 0, 0, 0);
        pulse();
        for (int i = 0; i < 40; i++) begin
            pulse();
            first[i] = div_val;
        end
        set_cfg(900, 2, 3, 0, 0, 0);
        pulse();
        repeat (5) pulse();
        set_cfg(800, 13, 29, 0, 0, 0);
        pulse();
        for (int i = 0; i < 40; i++) begin
            pulse();
            if (div_val != first[i]) diff++;
        end
        check(diff == 0, "R13 replay mismatches", diff, 0);
    endtask

    initial begin
        t_reset();
        t_zero_frac();
        t_int_mode();
        t_window(100,   37,   97,   0, 1, 0, 291);
        t_window(23,    4094, 4095, 0, 0, 0, 4095);
        t_window(65535, 1,    2,    1, 0, 0, 40);
        t_window(1000,  1,    4095, 0, 0, 0, 500);
        t_window(2000,  5,    97,   0, 0, 1, 194);
        t_limits();
        t_err_hold();
        t_no_strobe();
        t_replay();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYC, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule